// File: doc/BRIEF.md
# Stacked-Die Select and Master Routing

This block holds the select logic for a stack of identical memory dies that share one set of vertical links. Each die has a fixed one-hot identity: die `i` carries the identity with only bit `i` set. Each die also has a strap input that makes it the master. On the master die, a small controller takes host requests and puts them on the shared command bus. The bus carries the operation, the chip-select, the address and the write data. Every die, the master included, compares the chip-select on the bus with its own identity. A die enables its SRAM only when the two are equal.

Read data comes back over a shared return bus. Only the addressed die drives it, and every other die holds its share at zero, so the bus is a plain OR of all dies. The master turns the return into a host response. A chip-select that is zero or has more than one bit set matches no die, and the master raises an error pulse instead of a response. The top level instantiates the whole stack so that the shared buses can be seen and checked at the ports.

A request is accepted on a clock edge. It is on the command bus and at the SRAM enables for the following cycle. Its read response or error pulse is visible in the cycle after that.

Top module: `stack_die_sel`

## Requirements
- R1: While reset is held, and right after it, `cmd_drv_o`, `sram_en_o`, `rd_drv_o`, `host_rvalid_o`, `cs_err_o` and `host_rdata_o` are all zero.
- R2: In the cycle after a request is accepted, `cmd_drv_o` has exactly one bit set, and that bit is the die whose `master_sel_i` bit is set.
- R3: In that same cycle, `sram_en_o` equals the chip-select when the chip-select has exactly one bit set. Bit `i` stands for die `i`. At most one bit of `sram_en_o` is ever set.
- R4: A write with a valid chip-select stores its data only in the addressed die. The same address on every other die keeps its old content.
- R5: A read returns the addressed die's word on `host_rdata_o`, with `host_rvalid_o` high for one cycle. This happens in the second cycle after the request is accepted.
- R6: When read data returns, `rd_drv_o` has only the addressed die's bit set. That die had its SRAM enabled in the cycle before.
- R7: A chip-select of zero, or with two or more bits set, enables no SRAM and changes no stored data. It gives no read response. Instead, `cs_err_o` is high for one cycle in the second cycle after the request.
- R8: Any die can be master. After `master_sel_i` moves to another die, requests are driven from the new master and reach every die in the same way.
- R9: `cfg_err_o` is high whenever `master_sel_i` does not have exactly one bit set. When no bit is set, requests are ignored: nothing is driven and no SRAM is enabled.
- R10: Without an accepted request, the command bus stays idle, so `cmd_drv_o` and `sram_en_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the stack |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_sel_i | input | NUM_DIES | Master strap, one bit per die |
| host_req_i | input | 1 | Host request strobe, taken by the master |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_cs_i | input | NUM_DIES | Chip-select, bit i selects die i |
| host_addr_i | input | ADDR_W | Word address inside a die |
| host_wdata_i | input | DATA_W | Write data |
| host_rvalid_o | output | 1 | Read response valid |
| host_rdata_o | output | DATA_W | Read response data |
| cs_err_o | output | 1 | Invalid chip-select pulse from the master |
| cfg_err_o | output | 1 | Master strap is not one-hot |
| cmd_drv_o | output | NUM_DIES | Dies driving a command onto the bus this cycle |
| sram_en_o | output | NUM_DIES | Dies whose SRAM is enabled this cycle |
| rd_drv_o | output | NUM_DIES | Dies driving the read return bus this cycle |

## Verification
Suppose the compare logic in one die decodes the wrong identity. Then that die's `sram_en_o` bit is wrong in the very first cycle after the request. In the next cycle the read return shows the wrong `rd_drv_o` bit or the wrong data. A broken gate on the return bus ORs a stale word from an idle die into `host_rdata_o`, and that shows on the next read of any other die. A controller that drives from a non-master die shows in `cmd_drv_o` in the cycle after acceptance. A missed error decode shows either as a missing `cs_err_o` pulse two edges after the request or as a corrupted word on a later read-back.

// File: rtl/stack_sel_pkg.sv
package stack_sel_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10
  } cmd_op_e;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_sel_pkg::*;
#(
  parameter int NUM_DIES = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_en_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [NUM_DIES-1:0] cs_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  cmd_op_e             bus_op_i,
  input  logic [NUM_DIES-1:0] bus_cs_i,
  input  logic                rd_hit_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output cmd_op_e             op_o,
  output logic [NUM_DIES-1:0] cs_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                err_o,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o
);
  cmd_op_e             op_q;
  logic [NUM_DIES-1:0] cs_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ctl_en_i && req_i) begin
        op_q    <= we_i ? OP_WR : OP_RD;
        cs_q    <= cs_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else begin
        op_q    <= OP_IDLE;
        cs_q    <= '0;
        addr_q  <= '0;
        wdata_q <= '0;
      end
      // bad select seen on the bus: flag at read-return timing
      err_q <= ctl_en_i && (bus_op_i != OP_IDLE) && !$onehot(bus_cs_i);
    end
  end

  // non-master dies keep their bus contribution at zero
  assign op_o     = ctl_en_i ? op_q : OP_IDLE;
  assign cs_o     = ctl_en_i ? cs_q : '0;
  assign addr_o   = ctl_en_i ? addr_q : '0;
  assign wdata_o  = ctl_en_i ? wdata_q : '0;
  assign err_o    = err_q;
  assign rvalid_o = ctl_en_i && rd_hit_i;
  assign rdata_o  = ctl_en_i ? rd_data_i : '0;
endmodule

// File: rtl/stack_die_sram.sv
module stack_die_sram
  import stack_sel_pkg::*;
#(
  parameter int NUM_DIES = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int DIE_IDX  = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  cmd_op_e             bus_op_i,
  input  logic [NUM_DIES-1:0] bus_cs_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic                sram_en_o,
  output logic                rd_drv_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int                DEPTH  = 1 << ADDR_W;
  localparam logic [NUM_DIES-1:0] DIE_ID = NUM_DIES'(1) << DIE_IDX;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              rd_drv_q;
  logic              hit;

  assign hit       = (bus_op_i != OP_IDLE) && (bus_cs_i == DIE_ID);
  assign sram_en_o = hit;

  always_ff @(posedge clk_i) begin
    if (hit && bus_op_i == OP_WR) mem_q[bus_addr_i] <= bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      rd_drv_q <= 1'b0;
    end else begin
      rd_drv_q <= hit && (bus_op_i == OP_RD);
      if (hit && bus_op_i == OP_RD) rd_q <= mem_q[bus_addr_i];
    end
  end

  assign rd_drv_o  = rd_drv_q;
  assign rd_data_o = rd_drv_q ? rd_q : '0;
endmodule

// File: rtl/stack_die_sel.sv
module stack_die_sel
  import stack_sel_pkg::*;
#(
  parameter int NUM_DIES = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_DIES-1:0] master_sel_i,
  input  logic                host_req_i,
  input  logic                host_we_i,
  input  logic [NUM_DIES-1:0] host_cs_i,
  input  logic [ADDR_W-1:0]   host_addr_i,
  input  logic [DATA_W-1:0]   host_wdata_i,
  output logic                host_rvalid_o,
  output logic [DATA_W-1:0]   host_rdata_o,
  output logic                cs_err_o,
  output logic                cfg_err_o,
  output logic [NUM_DIES-1:0] cmd_drv_o,
  output logic [NUM_DIES-1:0] sram_en_o,
  output logic [NUM_DIES-1:0] rd_drv_o
);
  cmd_op_e             die_op    [NUM_DIES];
  logic [NUM_DIES-1:0] die_cs    [NUM_DIES];
  logic [ADDR_W-1:0]   die_addr  [NUM_DIES];
  logic [DATA_W-1:0]   die_wdata [NUM_DIES];
  logic [DATA_W-1:0]   die_rd    [NUM_DIES];
  logic [DATA_W-1:0]   die_hrd   [NUM_DIES];
  logic [NUM_DIES-1:0] die_err;
  logic [NUM_DIES-1:0] die_rvld;

  cmd_op_e             bus_op;
  logic [NUM_DIES-1:0] bus_cs;
  logic [ADDR_W-1:0]   bus_addr;
  logic [DATA_W-1:0]   bus_wdata;
  logic [DATA_W-1:0]   bus_rd;
  logic [DATA_W-1:0]   host_rd;

  // shared vertical buses: every idle contributor is zero, so OR merges
  always_comb begin
    bus_op    = OP_IDLE;
    bus_cs    = '0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_rd    = '0;
    host_rd   = '0;
    for (int i = 0; i < NUM_DIES; i++) begin
      bus_op    = cmd_op_e'(bus_op | die_op[i]);
      bus_cs    = bus_cs | die_cs[i];
      bus_addr  = bus_addr | die_addr[i];
      bus_wdata = bus_wdata | die_wdata[i];
      bus_rd    = bus_rd | die_rd[i];
      host_rd   = host_rd | die_hrd[i];
    end
  end

  for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
    stack_ctrl #(
      .NUM_DIES(NUM_DIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_en_i  (master_sel_i[g]),
      .req_i     (host_req_i),
      .we_i      (host_we_i),
      .cs_i      (host_cs_i),
      .addr_i    (host_addr_i),
      .wdata_i   (host_wdata_i),
      .bus_op_i  (bus_op),
      .bus_cs_i  (bus_cs),
      .rd_hit_i  (|rd_drv_o),
      .rd_data_i (bus_rd),
      .op_o      (die_op[g]),
      .cs_o      (die_cs[g]),
      .addr_o    (die_addr[g]),
      .wdata_o   (die_wdata[g]),
      .err_o     (die_err[g]),
      .rvalid_o  (die_rvld[g]),
      .rdata_o   (die_hrd[g])
    );

    assign cmd_drv_o[g] = (die_op[g] != OP_IDLE);

    stack_die_sram #(
      .NUM_DIES(NUM_DIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIE_IDX(g)
    ) u_sram (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bus_op_i    (bus_op),
      .bus_cs_i    (bus_cs),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .sram_en_o   (sram_en_o[g]),
      .rd_drv_o    (rd_drv_o[g]),
      .rd_data_o   (die_rd[g])
    );
  end

  assign host_rvalid_o = |die_rvld;
  assign host_rdata_o  = host_rd;
  assign cs_err_o      = |die_err;
  assign cfg_err_o     = !$onehot(master_sel_i);
endmodule

// File: rtl/stack_die_sel_chk.sv
module stack_die_sel_chk #(
  parameter int NUM_DIES = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_DIES-1:0] master_sel_i,
  input logic                host_req_i,
  input logic                host_rvalid_o,
  input logic                cs_err_o,
  input logic                cfg_err_o,
  input logic [NUM_DIES-1:0] cmd_drv_o,
  input logic [NUM_DIES-1:0] sram_en_o,
  input logic [NUM_DIES-1:0] rd_drv_o
);
  AST_ONE_CMD_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_err_o |-> $onehot0(cmd_drv_o)); // R2

  AST_DRIVER_IS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_drv_o & ~master_sel_i) == '0); // R8

  AST_EN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sram_en_o)); // R3

  AST_RD_FROM_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sram_en_o) |=> ((rd_drv_o & ~$past(sram_en_o)) == '0)); // R6

  AST_RD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_drv_o)); // R6

  AST_ERR_NO_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_err_o |-> (!host_rvalid_o && rd_drv_o == '0)); // R7

  AST_CMD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_drv_o) |-> $past(host_req_i)); // R10
endmodule

bind stack_die_sel stack_die_sel_chk #(.NUM_DIES(NUM_DIES)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .master_sel_i  (master_sel_i),
  .host_req_i    (host_req_i),
  .host_rvalid_o (host_rvalid_o),
  .cs_err_o      (cs_err_o),
  .cfg_err_o     (cfg_err_o),
  .cmd_drv_o     (cmd_drv_o),
  .sram_en_o     (sram_en_o),
  .rd_drv_o      (rd_drv_o)
);

// File: tb/stack_die_sel_tb_top.sv
module stack_die_sel_tb_top;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  master_sel = 4'b0001;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [N-1:0]  cs = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          rvalid, cs_err, cfg_err;
  logic [DW-1:0] rdata;
  logic [N-1:0]  cmd_drv, sram_en, rd_drv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [N][1 << AW];

  always #2.5 clk = ~clk;

  stack_die_sel #(.NUM_DIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_sel_i(master_sel),
    .host_req_i(req), .host_we_i(we), .host_cs_i(cs), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rvalid_o(rvalid), .host_rdata_o(rdata),
    .cs_err_o(cs_err), .cfg_err_o(cfg_err), .cmd_drv_o(cmd_drv),
    .sram_en_o(sram_en), .rd_drv_o(rd_drv)
  );

  task automatic chk(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int bit_idx(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  // one request, checked over the two cycles it occupies
  task automatic txn(string tag, logic t_we, logic [N-1:0] t_cs, logic [AW-1:0] t_addr,
                     logic [DW-1:0] t_wd);
    bit has_m = $onehot(master_sel);
    bit ok    = has_m && $onehot(t_cs);
    int d     = bit_idx(t_cs);
    logic [DW-1:0] exp_rd = ok ? ref_mem[d][t_addr] : '0;
    req = 1'b1; we = t_we; cs = t_cs; addr = t_addr; wdata = t_wd;
    @(negedge clk);
    req = 1'b0;
    chk(tag, "cmd_drv", 32'(cmd_drv), has_m ? 32'(master_sel) : 32'h0);
    chk(tag, "sram_en", 32'(sram_en), ok ? 32'(t_cs) : 32'h0);
    chk(tag, "early rvalid", 32'(rvalid), 32'h0);
    @(negedge clk);
    chk(tag, "rvalid", 32'(rvalid), (ok && !t_we) ? 32'h1 : 32'h0);
    chk(tag, "rd_drv", 32'(rd_drv), (ok && !t_we) ? 32'(t_cs) : 32'h0);
    if (ok && !t_we) chk(tag, "rdata", 32'(rdata), 32'(exp_rd));
    else chk(tag, "rdata idle", 32'(rdata), 32'h0);
    chk(tag, "cs_err", 32'(cs_err), (has_m && !$onehot(t_cs)) ? 32'h1 : 32'h0);
    if (ok && t_we) ref_mem[d][t_addr] = t_wd;
  endtask

  initial begin
    #1;
    chk("R1", "reset cmd_drv", 32'(cmd_drv), 32'h0);
    chk("R1", "reset rd_drv", 32'(rd_drv), 32'h0);
    chk("R1", "reset rvalid", 32'(rvalid), 32'h0);
    chk("R1", "reset cs_err", 32'(cs_err), 32'h0);
    chk("R1", "reset rdata", 32'(rdata), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle cmd_drv", 32'(cmd_drv), 32'h0);
    chk("R10", "idle sram_en", 32'(sram_en), 32'h0);
    chk("R9", "cfg ok", 32'(cfg_err), 32'h0);

    // master on die 0; seed each die at the same address
    txn("R4", 1'b1, 4'b0001, 6'd3, 16'hA001);
    txn("R4", 1'b1, 4'b0010, 6'd3, 16'hB002);
    txn("R4", 1'b1, 4'b0100, 6'd3, 16'hC003);
    txn("R4", 1'b1, 4'b1000, 6'd3, 16'hD004);
    txn("R4", 1'b1, 4'b1000, 6'd5, 16'h5E5E);
    for (int i = 0; i < N; i++) txn("R5", 1'b0, 4'(1 << i), 6'd3, 16'h0);
    txn("R6", 1'b0, 4'b1000, 6'd5, 16'h0);
    txn("R6", 1'b0, 4'b0100, 6'd3, 16'h0);

    // bad selects: no write, no response, error pulse
    txn("R7", 1'b1, 4'b0000, 6'd3, 16'hEEEE);
    txn("R7", 1'b1, 4'b0011, 6'd3, 16'hEEEE);
    txn("R7", 1'b0, 4'b0101, 6'd3, 16'h0);
    for (int i = 0; i < N; i++) txn("R7", 1'b0, 4'(1 << i), 6'd3, 16'h0);
    @(negedge clk);
    chk("R7", "err is a pulse", 32'(cs_err), 32'h0);

    // move the master
    master_sel = 4'b0100;
    @(negedge clk);
    txn("R8", 1'b1, 4'b0010, 6'd7, 16'h7777);
    txn("R8", 1'b0, 4'b0010, 6'd7, 16'h0);
    master_sel = 4'b1000;
    @(negedge clk);
    txn("R8", 1'b0, 4'b0001, 6'd3, 16'h0);
    txn("R8", 1'b1, 4'b1000, 6'd3, 16'h1234);
    txn("R8", 1'b0, 4'b1000, 6'd3, 16'h0);

    // bad strap
    master_sel = 4'b0000;
    #1;
    chk("R9", "cfg zero", 32'(cfg_err), 32'h1);
    @(negedge clk);
    txn("R9", 1'b1, 4'b0001, 6'd3, 16'hDEAD);
    master_sel = 4'b0110;
    #1;
    chk("R9", "cfg two", 32'(cfg_err), 32'h1);
    master_sel = 4'b0001;
    #1;
    chk("R9", "cfg restored", 32'(cfg_err), 32'h0);
    @(negedge clk);
    txn("R9", 1'b0, 4'b0001, 6'd3, 16'h0);
    @(negedge clk);
    chk("R10", "final idle", 32'(cmd_drv | sram_en | rd_drv), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule